// File: doc/BRIEF.md
# TPM Register Hardware-Return Responder

This block sits behind the command/address capture of a TPM-over-SPI target. For each decoded transaction it gets the direction bit, the transfer length and the 24-bit address. It then chooses one of three outcomes: it answers a register read with hardware-held data, it hands the whole command to software, or it silently drops a write. The choice depends on four configuration inputs:

- a CRB interface select, under which hardware never answers,
- a switch that forces every command to software,
- a switch that waives the fixed upper-address prefix,
- a switch that sends out-of-range localities to software instead of answering them with all-ones.

The block keeps its own copies of the small TPM registers that hardware answers from. These are one access byte per locality, plus the status word, the interface-capability word, the interrupt-enable word, the interrupt-vector byte, the interrupt-status word, the vendor/device identity word and the revision byte. A simple write port loads these copies. The outcome comes out one clock after the command strobe. An upload also latches the command into a capture holding register, whose valid flag stays set until software acknowledges it.

Top module: `tpm_hw_responder`

## Requirements
- R1: One cycle after `cmd_valid`, a read of a known register with a valid locality and a matching prefix returns `resp_kind` 0 (hardware read). `resp_data` byte i (bits 8i+7:8i) is register byte (addr[1:0]+i) mod 4, so the register comes out least-significant byte first from the addressed byte. The register word offsets in addr[11:0] are: access 0x000, interrupt enable 0x008, interrupt vector 0x00C, interrupt status 0x010, interface capability 0x014, status 0x018, identity 0xF00, revision 0xF04.
- R2: Any address outside that register set gives `resp_kind` 1 (upload). Its direction, length and address appear on `cap_write`, `cap_len` and `cap_addr`.
- R3: Unless `cfg_prefix_any` is high, an address whose bits [23:16] are not 0xD4 is uploaded. With the waiver high, the prefix is not examined.
- R4: The locality is addr[15:12]. When it is at or above the supported count and `cfg_loc_any` is low, a read returns kind 0 with every data byte 0xFF, and a write returns `resp_kind` 2 (discard) and leaves the capture register untouched.
- R5: With `cfg_loc_any` high, an out-of-range locality is uploaded for both reads and writes.
- R6: With `cfg_crb` or `cfg_hwret_off` high, every command is uploaded.
- R7: A write to a known register with a valid locality is uploaded. Hardware never answers a write.
- R8: Each locality has its own 8-bit access register. Parameter `MULTI_LOC` set to 1 gives five localities, and set to 0 gives one. The status word is shared by all localities.
- R9: The identity word carries the vendor ID in bits 15:0 and the device ID in bits 31:16. The revision and interrupt-vector registers are 8 bits wide and read back as zero in their upper bytes.
- R10: `cap_valid` rises only on an upload and stays high until a `sw_clr_valid` pulse. An upload in the same cycle as a clear leaves it high.
- R11: All held registers reset to zero. A write on the software port takes effect for the next command. `sw_sel` codes are: 0 access, 1 status, 2 interface capability, 3 interrupt enable, 4 interrupt vector, 5 interrupt status, 6 identity, 7 revision. An access write with `sw_loc` at or above the supported count is ignored.
- R12: `resp_valid` is a one-cycle pulse exactly one cycle after each `cmd_valid`, and is low otherwise.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| cmd_valid | input | 1 | Decoded command strobe |
| cmd_write | input | 1 | 1 = write transaction |
| cmd_len | input | LEN_W | Transfer length field, passed to capture |
| cmd_addr | input | 24 | Transaction address |
| cfg_crb | input | 1 | CRB interface selected |
| cfg_hwret_off | input | 1 | Force all commands to software |
| cfg_prefix_any | input | 1 | Waive the 0xD4 prefix check |
| cfg_loc_any | input | 1 | Upload out-of-range localities |
| sw_we | input | 1 | Software register write strobe |
| sw_sel | input | 3 | Register select for software write |
| sw_loc | input | 4 | Locality for access-register writes |
| sw_wdata | input | 32 | Software write data |
| sw_clr_valid | input | 1 | Acknowledge captured command |
| resp_valid | output | 1 | Outcome strobe |
| resp_kind | output | 2 | 0 hardware read, 1 upload, 2 discard |
| resp_data | output | RD_BYTES*8 | Read bytes, first byte in bits 7:0 |
| cap_valid | output | 1 | Captured command pending for software |
| cap_write | output | 1 | Captured direction |
| cap_len | output | LEN_W | Captured length |
| cap_addr | output | 24 | Captured address |

## Verification
The table is applied with every register class and with several byte offsets inside the identity word. This separates a correct least-significant-first rotation from a fixed-lane or reversed read. Both prefix values are applied with and without the waiver, and the interface and disable switches are applied one at a time, so each gating term is shown to act on its own. Localities 1, 2 and 4 are applied to separate per-locality storage, and localities 5 and 15 are applied as reads, writes and under the waiver, to tell the all-ones answer, the discard and the upload apart. Directed cases cover the clear/upload collision, a software write to a nonexistent locality, and a register change that must show up on the very next command.

// File: rtl/tpm_rbh_pkg.sv
package tpm_rbh_pkg;

   typedef enum logic [1:0] {
      RESP_HWREAD  = 2'd0,
      RESP_UPLOAD  = 2'd1,
      RESP_DISCARD = 2'd2
   } resp_kind_e;

   typedef enum logic [3:0] {
      RC_NONE,
      RC_ACCESS,
      RC_INT_EN,
      RC_INT_VEC,
      RC_INT_STS,
      RC_INTF_CAP,
      RC_STS,
      RC_IDENT,
      RC_REV
   } reg_class_e;

   localparam logic [2:0] SW_ACCESS   = 3'd0;
   localparam logic [2:0] SW_STS      = 3'd1;
   localparam logic [2:0] SW_INTF_CAP = 3'd2;
   localparam logic [2:0] SW_INT_EN   = 3'd3;
   localparam logic [2:0] SW_INT_VEC  = 3'd4;
   localparam logic [2:0] SW_INT_STS  = 3'd5;
   localparam logic [2:0] SW_IDENT    = 3'd6;
   localparam logic [2:0] SW_REV      = 3'd7;

   localparam int unsigned ADDR_W = 24;
   localparam int unsigned LOC_W  = 4;
   localparam logic [7:0]  REGION_PREFIX = 8'hD4;

   function automatic reg_class_e classify_offset(input logic [11:0] off);
      reg_class_e rc;
      case (off[11:2])
         10'h000: rc = RC_ACCESS;
         10'h002: rc = RC_INT_EN;
         10'h003: rc = RC_INT_VEC;
         10'h004: rc = RC_INT_STS;
         10'h005: rc = RC_INTF_CAP;
         10'h006: rc = RC_STS;
         10'h3C0: rc = RC_IDENT;
         10'h3C1: rc = RC_REV;
         default: rc = RC_NONE;
      endcase
      return rc;
   endfunction

endpackage

// File: rtl/tpm_rbh_regfile.sv
module tpm_rbh_regfile
   import tpm_rbh_pkg::*;
#(
   parameter int unsigned NUM_LOC = 5
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             sw_we,
   input  logic [2:0]       sw_sel,
   input  logic [LOC_W-1:0] sw_loc,
   input  logic [31:0]      sw_wdata,
   input  reg_class_e       rd_class,
   input  logic [LOC_W-1:0] rd_loc,
   output logic [31:0]      rd_word
);

   logic [7:0]  access_q [NUM_LOC];
   logic [31:0] sts_q, cap_q, int_en_q, int_sts_q, ident_q;
   logic [7:0]  int_vec_q, rev_q;

   for (genvar g = 0; g < NUM_LOC; g++) begin : g_loc
      always_ff @(posedge clk or negedge rst_n) begin
         if (!rst_n) begin
            access_q[g] <= '0;
         end else if (sw_we && sw_sel == SW_ACCESS && sw_loc == LOC_W'(g)) begin
            access_q[g] <= sw_wdata[7:0];
         end
      end
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         sts_q     <= '0;
         cap_q     <= '0;
         int_en_q  <= '0;
         int_sts_q <= '0;
         ident_q   <= '0;
         int_vec_q <= '0;
         rev_q     <= '0;
      end else if (sw_we) begin
         case (sw_sel)
            SW_STS:      sts_q     <= sw_wdata;
            SW_INTF_CAP: cap_q     <= sw_wdata;
            SW_INT_EN:   int_en_q  <= sw_wdata;
            SW_INT_VEC:  int_vec_q <= sw_wdata[7:0];
            SW_INT_STS:  int_sts_q <= sw_wdata;
            SW_IDENT:    ident_q   <= sw_wdata;
            SW_REV:      rev_q     <= sw_wdata[7:0];
            default: ;
         endcase
      end
   end

   logic [7:0] access_sel;

   always_comb begin
      access_sel = '0;
      for (int i = 0; i < NUM_LOC; i++) begin
         if (rd_loc == LOC_W'(i)) access_sel = access_q[i];
      end
   end

   always_comb begin
      case (rd_class)
         RC_ACCESS:   rd_word = {24'h0, access_sel};
         RC_INT_EN:   rd_word = int_en_q;
         RC_INT_VEC:  rd_word = {24'h0, int_vec_q};
         RC_INT_STS:  rd_word = int_sts_q;
         RC_INTF_CAP: rd_word = cap_q;
         RC_STS:      rd_word = sts_q;
         RC_IDENT:    rd_word = ident_q;
         RC_REV:      rd_word = {24'h0, rev_q};
         default:     rd_word = '0;
      endcase
   end

endmodule

// File: rtl/tpm_rbh_decide.sv
module tpm_rbh_decide
   import tpm_rbh_pkg::*;
#(
   parameter int unsigned NUM_LOC = 5
) (
   input  logic              cmd_write,
   input  logic [ADDR_W-1:0] cmd_addr,
   input  logic              cfg_crb,
   input  logic              cfg_hwret_off,
   input  logic              cfg_prefix_any,
   input  logic              cfg_loc_any,
   output resp_kind_e        kind,
   output logic              fill_ones,
   output reg_class_e        rd_class,
   output logic [LOC_W-1:0]  rd_loc
);

   logic hw_enabled, prefix_ok, loc_ok, known_reg;

   assign rd_loc     = cmd_addr[15:12];
   assign rd_class   = classify_offset(cmd_addr[11:0]);
   assign known_reg  = (rd_class != RC_NONE);
   assign hw_enabled = !cfg_crb && !cfg_hwret_off;
   assign prefix_ok  = cfg_prefix_any || (cmd_addr[23:16] == REGION_PREFIX);
   assign loc_ok     = ({1'b0, rd_loc} < (LOC_W + 1)'(NUM_LOC));

   always_comb begin
      kind      = RESP_UPLOAD;
      fill_ones = 1'b0;
      if (hw_enabled && prefix_ok && known_reg) begin
         if (!loc_ok) begin
            if (!cfg_loc_any) begin
               if (cmd_write) begin
                  kind = RESP_DISCARD;
               end else begin
                  kind      = RESP_HWREAD;
                  fill_ones = 1'b1;
               end
            end
         end else if (!cmd_write) begin
            kind = RESP_HWREAD;
         end
      end
   end

endmodule

// File: rtl/tpm_rbh_capture.sv
module tpm_rbh_capture
   import tpm_rbh_pkg::*;
#(
   parameter int unsigned LEN_W = 6
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              load,
   input  logic              clr,
   input  logic              in_write,
   input  logic [LEN_W-1:0]  in_len,
   input  logic [ADDR_W-1:0] in_addr,
   output logic              valid,
   output logic              out_write,
   output logic [LEN_W-1:0]  out_len,
   output logic [ADDR_W-1:0] out_addr
);

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         valid     <= 1'b0;
         out_write <= 1'b0;
         out_len   <= '0;
         out_addr  <= '0;
      end else if (load) begin
         valid     <= 1'b1;
         out_write <= in_write;
         out_len   <= in_len;
         out_addr  <= in_addr;
      end else if (clr) begin
         valid <= 1'b0;
      end
   end

endmodule

// File: rtl/tpm_hw_responder.sv
module tpm_hw_responder
   import tpm_rbh_pkg::*;
#(
   parameter bit          MULTI_LOC = 1'b1,
   parameter int unsigned RD_BYTES  = 4,
   parameter int unsigned LEN_W     = 6
) (
   input  logic                  clk,
   input  logic                  rst_n,
   input  logic                  cmd_valid,
   input  logic                  cmd_write,
   input  logic [LEN_W-1:0]      cmd_len,
   input  logic [23:0]           cmd_addr,
   input  logic                  cfg_crb,
   input  logic                  cfg_hwret_off,
   input  logic                  cfg_prefix_any,
   input  logic                  cfg_loc_any,
   input  logic                  sw_we,
   input  logic [2:0]            sw_sel,
   input  logic [3:0]            sw_loc,
   input  logic [31:0]           sw_wdata,
   input  logic                  sw_clr_valid,
   output logic                  resp_valid,
   output logic [1:0]            resp_kind,
   output logic [RD_BYTES*8-1:0] resp_data,
   output logic                  cap_valid,
   output logic                  cap_write,
   output logic [LEN_W-1:0]      cap_len,
   output logic [23:0]           cap_addr
);

   localparam int unsigned NUM_LOC = MULTI_LOC ? 5 : 1;
   localparam int unsigned DATA_W  = RD_BYTES * 8;

   if (RD_BYTES < 1 || RD_BYTES > 8) begin : g_bad_rd_bytes
      $error("RD_BYTES must lie in 1..8");
   end
   if (LEN_W < 1 || LEN_W > 16) begin : g_bad_len_w
      $error("LEN_W must lie in 1..16");
   end

   resp_kind_e       kind_d;
   logic             fill_ones;
   reg_class_e       rd_class;
   logic [LOC_W-1:0] rd_loc;
   logic [31:0]      rd_word;
   logic [DATA_W-1:0] data_d;

   tpm_rbh_decide #(.NUM_LOC(NUM_LOC)) u_decide (
      .cmd_write      (cmd_write),
      .cmd_addr       (cmd_addr),
      .cfg_crb        (cfg_crb),
      .cfg_hwret_off  (cfg_hwret_off),
      .cfg_prefix_any (cfg_prefix_any),
      .cfg_loc_any    (cfg_loc_any),
      .kind           (kind_d),
      .fill_ones      (fill_ones),
      .rd_class       (rd_class),
      .rd_loc         (rd_loc)
   );

   tpm_rbh_regfile #(.NUM_LOC(NUM_LOC)) u_regs (
      .clk      (clk),
      .rst_n    (rst_n),
      .sw_we    (sw_we),
      .sw_sel   (sw_sel),
      .sw_loc   (sw_loc),
      .sw_wdata (sw_wdata),
      .rd_class (rd_class),
      .rd_loc   (rd_loc),
      .rd_word  (rd_word)
   );

   for (genvar b = 0; b < RD_BYTES; b++) begin : g_lane
      logic [1:0] lane_sel;
      assign lane_sel = cmd_addr[1:0] + 2'(b);
      assign data_d[8*b +: 8] = fill_ones ? 8'hFF : rd_word[8*lane_sel +: 8];
   end

   tpm_rbh_capture #(.LEN_W(LEN_W)) u_cap (
      .clk       (clk),
      .rst_n     (rst_n),
      .load      (cmd_valid && kind_d == RESP_UPLOAD),
      .clr       (sw_clr_valid),
      .in_write  (cmd_write),
      .in_len    (cmd_len),
      .in_addr   (cmd_addr),
      .valid     (cap_valid),
      .out_write (cap_write),
      .out_len   (cap_len),
      .out_addr  (cap_addr)
   );

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         resp_valid <= 1'b0;
         resp_kind  <= RESP_HWREAD;
         resp_data  <= '0;
      end else begin
         resp_valid <= cmd_valid;
         if (cmd_valid) begin
            resp_kind <= kind_d;
            resp_data <= (kind_d == RESP_HWREAD) ? data_d : '0;
         end
      end
   end

endmodule

// File: rtl/tpm_rbh_checker.sv
module tpm_rbh_checker (
   input logic        clk,
   input logic        rst_n,
   input logic        cmd_valid,
   input logic        cmd_write,
   input logic [23:0] cmd_addr,
   input logic        cfg_crb,
   input logic        cfg_hwret_off,
   input logic        cfg_prefix_any,
   input logic        resp_valid,
   input logic [1:0]  resp_kind,
   input logic        cap_valid,
   input logic [23:0] cap_addr
);

   assert_resp_follows_cmd_R12: assert property (@(posedge clk) disable iff (!rst_n)
      cmd_valid |=> resp_valid);

   assert_resp_only_after_cmd_R12: assert property (@(posedge clk) disable iff (!rst_n)
      !cmd_valid |=> !resp_valid);

   assert_iface_off_uploads_R6: assert property (@(posedge clk) disable iff (!rst_n)
      (cmd_valid && (cfg_crb || cfg_hwret_off)) |=> (resp_kind == 2'd1));

   assert_prefix_miss_uploads_R3: assert property (@(posedge clk) disable iff (!rst_n)
      (cmd_valid && !cfg_prefix_any && cmd_addr[23:16] != 8'hD4) |=> (resp_kind == 2'd1));

   assert_write_not_answered_R7: assert property (@(posedge clk) disable iff (!rst_n)
      (cmd_valid && cmd_write) |=> (resp_kind != 2'd0));

   assert_upload_sets_flag_R10: assert property (@(posedge clk) disable iff (!rst_n)
      (resp_valid && resp_kind == 2'd1) |-> cap_valid);

   assert_flag_rise_on_upload_R10: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(cap_valid) |-> (resp_valid && resp_kind == 2'd1));

   assert_discard_keeps_capture_R4: assert property (@(posedge clk) disable iff (!rst_n)
      (resp_valid && resp_kind == 2'd2) |-> $stable(cap_addr));

endmodule

bind tpm_hw_responder tpm_rbh_checker u_chk (
   .clk            (clk),
   .rst_n          (rst_n),
   .cmd_valid      (cmd_valid),
   .cmd_write      (cmd_write),
   .cmd_addr       (cmd_addr),
   .cfg_crb        (cfg_crb),
   .cfg_hwret_off  (cfg_hwret_off),
   .cfg_prefix_any (cfg_prefix_any),
   .resp_valid     (resp_valid),
   .resp_kind      (resp_kind),
   .cap_valid      (cap_valid),
   .cap_addr       (cap_addr)
);

// File: tb/tb_tpm_hw_responder.sv
module tb_tpm_hw_responder;

   localparam time CLK_PERIOD = 10ns;
   localparam int  NV = 25;

   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic        cmd_valid = 1'b0, cmd_write = 1'b0;
   logic [5:0]  cmd_len = 6'd3;
   logic [23:0] cmd_addr = '0;
   logic        cfg_crb = 1'b0, cfg_hwret_off = 1'b0, cfg_prefix_any = 1'b0, cfg_loc_any = 1'b0;
   logic        sw_we = 1'b0;
   logic [2:0]  sw_sel = '0;
   logic [3:0]  sw_loc = '0;
   logic [31:0] sw_wdata = '0;
   logic        sw_clr_valid = 1'b0;
   logic        resp_valid;
   logic [1:0]  resp_kind;
   logic [31:0] resp_data;
   logic        cap_valid, cap_write;
   logic [5:0]  cap_len;
   logic [23:0] cap_addr;

   int checks = 0;
   int fails  = 0;

   tpm_hw_responder dut (
      .clk(clk), .rst_n(rst_n), .cmd_valid(cmd_valid), .cmd_write(cmd_write),
      .cmd_len(cmd_len), .cmd_addr(cmd_addr), .cfg_crb(cfg_crb),
      .cfg_hwret_off(cfg_hwret_off), .cfg_prefix_any(cfg_prefix_any),
      .cfg_loc_any(cfg_loc_any), .sw_we(sw_we), .sw_sel(sw_sel), .sw_loc(sw_loc),
      .sw_wdata(sw_wdata), .sw_clr_valid(sw_clr_valid), .resp_valid(resp_valid),
      .resp_kind(resp_kind), .resp_data(resp_data), .cap_valid(cap_valid),
      .cap_write(cap_write), .cap_len(cap_len), .cap_addr(cap_addr)
   );

   always #(CLK_PERIOD/2) clk = ~clk;

   // vector: {req[3:0], write, addr[23:0], cfg{crb,hwoff,prefix_any,loc_any}, kind[1:0], data[31:0]}
   localparam logic [66:0] VEC [NV] = '{
      {4'd1,  1'b0, 24'hD40F00, 4'b0000, 2'd0, 32'h1234ABCD}, // R1
      {4'd1,  1'b0, 24'hD40F02, 4'b0000, 2'd0, 32'hABCD1234}, // R1
      {4'd9,  1'b0, 24'hD40F04, 4'b0000, 2'd0, 32'h0000005A}, // R9
      {4'd1,  1'b0, 24'hD40018, 4'b0000, 2'd0, 32'h88442211}, // R1
      {4'd8,  1'b0, 24'hD41018, 4'b0000, 2'd0, 32'h88442211}, // R8
      {4'd8,  1'b0, 24'hD42000, 4'b0000, 2'd0, 32'h000000A2}, // R8
      {4'd8,  1'b0, 24'hD44000, 4'b0000, 2'd0, 32'h000000A4}, // R8
      {4'd1,  1'b0, 24'hD40001, 4'b0000, 2'd0, 32'hA0000000}, // R1
      {4'd4,  1'b0, 24'hD45018, 4'b0000, 2'd0, 32'hFFFFFFFF}, // R4
      {4'd4,  1'b1, 24'hD45018, 4'b0000, 2'd2, 32'h00000000}, // R4
      {4'd5,  1'b0, 24'hD45018, 4'b0001, 2'd1, 32'h00000000}, // R5
      {4'd3,  1'b0, 24'hD30018, 4'b0000, 2'd1, 32'h00000000}, // R3
      {4'd3,  1'b0, 24'hD30018, 4'b0010, 2'd0, 32'h88442211}, // R3
      {4'd6,  1'b0, 24'hD40018, 4'b1000, 2'd1, 32'h00000000}, // R6
      {4'd6,  1'b0, 24'hD40018, 4'b0100, 2'd1, 32'h00000000}, // R6
      {4'd7,  1'b1, 24'hD40018, 4'b0000, 2'd1, 32'h00000000}, // R7
      {4'd2,  1'b0, 24'hD40020, 4'b0000, 2'd1, 32'h00000000}, // R2
      {4'd9,  1'b0, 24'hD4000C, 4'b0000, 2'd0, 32'h00000007}, // R9
      {4'd1,  1'b0, 24'hD40014, 4'b0000, 2'd0, 32'hCAFE0F0F}, // R1
      {4'd1,  1'b0, 24'hD40008, 4'b0000, 2'd0, 32'h80000003}, // R1
      {4'd1,  1'b0, 24'hD40010, 4'b0000, 2'd0, 32'h00000011}, // R1
      {4'd9,  1'b0, 24'hD40F03, 4'b0000, 2'd0, 32'h34ABCD12}, // R9
      {4'd3,  1'b0, 24'hD36000, 4'b0000, 2'd1, 32'h00000000}, // R3
      {4'd4,  1'b0, 24'hD4F000, 4'b0000, 2'd0, 32'hFFFFFFFF}, // R4
      {4'd5,  1'b1, 24'hD4F000, 4'b0001, 2'd1, 32'h00000000}  // R5
   };

   task automatic check(input bit ok, input string req, input logic [31:0] act,
                        input logic [31:0] exp);
      checks++;
      if (!ok) begin
         fails++;
         $display("FAIL %s actual=%h expected=%h", req, act, exp);
      end
   endtask

   task automatic sw_write(input logic [2:0] sel, input logic [3:0] loc, input logic [31:0] d);
      @(negedge clk);
      sw_we = 1'b1; sw_sel = sel; sw_loc = loc; sw_wdata = d;
      @(negedge clk);
      sw_we = 1'b0;
   endtask

   // drive one command; on return the registered outcome is sampled-stable
   task automatic issue(input logic w, input logic [23:0] a, input logic [3:0] cfg,
                        input logic clr);
      @(negedge clk);
      cmd_valid = 1'b1; cmd_write = w; cmd_addr = a;
      {cfg_crb, cfg_hwret_off, cfg_prefix_any, cfg_loc_any} = cfg;
      sw_clr_valid = clr;
      @(negedge clk);
      cmd_valid = 1'b0; sw_clr_valid = 1'b0;
   endtask

   initial begin : watchdog
      repeat (20000) @(posedge clk);
      fails++;
      $display("FAIL watchdog expired");
      $display("== %0d vectors applied, %0d miscompares ==", checks, fails);
      $finish;
   end

   initial begin : stim
      logic [23:0] last_cap;
      repeat (3) @(negedge clk);
      // R12 / R10: reset state
      check(resp_valid == 1'b0, "R12 reset resp_valid", 32'(resp_valid), 32'h0);
      check(cap_valid == 1'b0, "R10 reset cap_valid", 32'(cap_valid), 32'h0);
      rst_n = 1'b1;
      // R11: held registers reset to zero
      issue(1'b0, 24'hD40F00, 4'b0000, 1'b0);
      check(resp_valid && resp_kind == 2'd0 && resp_data == 32'h0, "R11 reset ident",
            resp_data, 32'h0);

      sw_write(3'd6, 4'd0, 32'h1234ABCD);
      sw_write(3'd1, 4'd0, 32'h88442211);
      sw_write(3'd7, 4'd0, 32'h0000FF5A);
      sw_write(3'd4, 4'd0, 32'h00000307);
      sw_write(3'd2, 4'd0, 32'hCAFE0F0F);
      sw_write(3'd3, 4'd0, 32'h80000003);
      sw_write(3'd5, 4'd0, 32'h00000011);
      for (int l = 0; l < 5; l++) sw_write(3'd0, 4'(l), 32'hA0 + 32'(l));

      last_cap = '0;
      for (int i = 0; i < NV; i++) begin
         logic [3:0]  req;
         logic        w;
         logic [23:0] a;
         logic [3:0]  cfg;
         logic [1:0]  k;
         logic [31:0] d;
         string       tag;
         {req, w, a, cfg, k, d} = VEC[i];
         tag = $sformatf("R%0d vec%0d", req, i);
         issue(w, a, cfg, 1'b0);
         check(resp_valid == 1'b1, {tag, " valid"}, 32'(resp_valid), 32'h1);
         check(resp_kind == k, {tag, " kind"}, 32'(resp_kind), 32'(k));
         if (k == 2'd0) check(resp_data == d, {tag, " data"}, resp_data, d);
         if (k == 2'd1) begin
            // R2: capture holds the uploaded command
            check(cap_valid && cap_addr == a && cap_write == w && cap_len == 6'd3,
                  {tag, " R2 capture"}, 32'(cap_addr), 32'(a));
            last_cap = a;
         end
         if (k == 2'd2)
            check(cap_addr == last_cap, {tag, " discard keeps capture"},
                  32'(cap_addr), 32'(last_cap));
      end

      // R12: pulse drops the cycle after
      @(negedge clk);
      check(resp_valid == 1'b0, "R12 single pulse", 32'(resp_valid), 32'h0);

      // R10: clear drops the flag
      @(negedge clk); sw_clr_valid = 1'b1;
      @(negedge clk); sw_clr_valid = 1'b0;
      check(cap_valid == 1'b0, "R10 clear", 32'(cap_valid), 32'h0);

      // R4: discard with nothing pending keeps flag low
      issue(1'b1, 24'hD45000, 4'b0000, 1'b0);
      check(resp_kind == 2'd2 && cap_valid == 1'b0, "R4 discard no capture",
            32'(cap_valid), 32'h0);

      // R10: upload and clear in the same cycle keeps flag high
      issue(1'b0, 24'hD40020, 4'b0000, 1'b1);
      check(cap_valid == 1'b1 && cap_addr == 24'hD40020, "R10 upload beats clear",
            32'(cap_valid), 32'h1);

      // R11: access write to nonexistent locality ignored
      sw_write(3'd0, 4'd5, 32'h00000077);
      issue(1'b0, 24'hD40000, 4'b0000, 1'b0);
      check(resp_data == 32'h000000A0, "R11 loc0 untouched", resp_data, 32'hA0);
      issue(1'b0, 24'hD41000, 4'b0000, 1'b0);
      check(resp_data == 32'h000000A1, "R11 loc1 untouched", resp_data, 32'hA1);
      issue(1'b0, 24'hD45000, 4'b0000, 1'b0);
      check(resp_data == 32'hFFFFFFFF, "R4 loc5 still ones", resp_data, 32'hFFFFFFFF);

      // R11: software update visible to the next command
      sw_write(3'd1, 4'd0, 32'h0BADF00D);
      issue(1'b0, 24'hD40018, 4'b0000, 1'b0);
      check(resp_data == 32'h0BADF00D, "R11 sts update", resp_data, 32'h0BADF00D);

      $display("== %0d vectors applied, %0d miscompares ==", checks, fails);
      $finish;
   end

endmodule